// File: doc/BRIEF.md
# I2C Byte Handshake Flag with Clock Hold and Interrupt

This block keeps the per-byte handshake flag of a multi-master I2C controller. The flag idles high. When the shift engine reports that a byte has finished, the flag drops. The engine raises that report on the falling edge of the last SCL pulse of the byte, and the acknowledge pulse counts as part of the byte. While the flag is low, the block asks the pad logic to keep SCL low, so every device on the bus waits for software.

Software releases the bus by writing a one into the flag bit of the control register, or by writing the data shift register or the transmit buffer. The flag does not rise at once. A release timer has to run out first, so the flag reads high a fixed number of clocks after the write. A falling flag produces a one-cycle interrupt pulse. A STOP condition seen while acting as a slave produces the same pulse, even though the flag does not move. Turning the enable off forces the flag high and lets SCL go.

Top module: `i2c_byte_handshake`

## Requirements
- R1: After reset, `byte_flag` is 1 and `irq` and `scl_hold` are 0. A reset asserted while the flag is low also returns the block to this state.
- R2: With `enable` high, an `evt_byte_done` or `evt_arb_lost` strobe drives `byte_flag` to 0 on the next clock edge.
- R3: An `evt_addr_done` strobe clears the flag only when `slave_rx` is 1. With `addr_fmt` = 0 it clears only when `addr_match` = 1. With `addr_fmt` = 1 it clears for any address byte. With `slave_rx` = 0 it has no effect.
- R4: `scl_hold` is 1 exactly when `byte_flag` is 0.
- R5: Each 1-to-0 transition of `byte_flag` raises `irq` in the same cycle, and the pulse lasts one cycle.
- R6: An `evt_stop` strobe with `is_slave` = 1 raises `irq` for one cycle without changing `byte_flag`. With `is_slave` = 0 it raises nothing.
- R7: While the flag is 0, any of these starts the release: `wr_ctrl` with `wr_ctrl_flag` = 1, `wr_shift`, or `wr_txbuf`. The flag then reads 1 after exactly RELEASE_CYC (default 8) clock edges counted from the write edge. A `wr_ctrl` with `wr_ctrl_flag` = 0 has no effect.
- R8: A clearing event that arrives while the release timer runs cancels the release, and the flag stays 0.
- R9: With `enable` = 0, the flag is 1 after the next edge. No `irq` is raised, and neither clear events nor `evt_stop` have any effect.
- R10: A release write while the flag is already 1 leaves the flag at 1 and raises no `irq`.
- R11: When a clearing event and a release write arrive in the same cycle, the clear wins and no release follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Interface enable |
| addr_fmt | input | 1 | Address format mode: 1 means any address byte clears the flag |
| slave_rx | input | 1 | Controller is a slave receiver |
| is_slave | input | 1 | Controller is acting as a slave |
| evt_byte_done | input | 1 | Byte (including ACK) finished, strobe |
| evt_arb_lost | input | 1 | Byte ended in arbitration loss, strobe |
| evt_addr_done | input | 1 | Address byte received, strobe |
| addr_match | input | 1 | Own or general-call address matched |
| evt_stop | input | 1 | STOP condition detected, strobe |
| wr_ctrl | input | 1 | Control register write strobe |
| wr_ctrl_flag | input | 1 | Value written to the flag bit |
| wr_shift | input | 1 | Data shift register write strobe |
| wr_txbuf | input | 1 | Transmit buffer write strobe |
| byte_flag | output | 1 | Handshake flag |
| irq | output | 1 | One-cycle interrupt request |
| scl_hold | output | 1 | Hold SCL low |

## Verification
A wrong internal state shows up at the ports right away. A flag left low shows as `scl_hold` stuck high. A clear that was missed shows as an `irq` that never comes on the edge after the strobe. A release timer with the wrong count makes `byte_flag` rise one or more cycles early or late against the edge counted from the write. A release that should have been cancelled shows as the flag rising within RELEASE_CYC cycles of a clear, so checks that sample at those exact cycles catch it.

// File: rtl/i2c_byte_handshake_pkg.sv
package i2c_byte_handshake_pkg;

  // Decide whether a received address byte ends the address phase hold.
  function automatic logic f_addr_clears(input logic fmt_any, input logic matched);
    return fmt_any | matched;
  endfunction

  // One step of the release countdown.
  function automatic logic [7:0] f_count_step(input logic [7:0] cnt);
    return (cnt == 8'd0) ? 8'd0 : cnt - 8'd1;
  endfunction

endpackage

// File: rtl/i2c_byte_handshake_clrdec.sv
module i2c_byte_handshake_clrdec
  import i2c_byte_handshake_pkg::*;
(
  input  logic enable,
  input  logic slave_rx,
  input  logic addr_fmt,
  input  logic evt_byte_done,
  input  logic evt_arb_lost,
  input  logic evt_addr_done,
  input  logic addr_match,
  input  logic wr_ctrl,
  input  logic wr_ctrl_flag,
  input  logic wr_shift,
  input  logic wr_txbuf,
  output logic clr_evt,
  output logic set_req
);
  logic addr_clr;

  always_comb begin
    addr_clr = evt_addr_done & slave_rx & f_addr_clears(addr_fmt, addr_match);
    clr_evt  = enable & (evt_byte_done | evt_arb_lost | addr_clr);
    set_req  = enable & ((wr_ctrl & wr_ctrl_flag) | wr_shift | wr_txbuf);
  end
endmodule

// File: rtl/i2c_byte_handshake_reltmr.sv
module i2c_byte_handshake_reltmr
  import i2c_byte_handshake_pkg::*;
#(
  parameter int RELEASE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic cancel,
  output logic expire,
  output logic busy
);
  localparam int CW = $clog2(RELEASE_CYC + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(RELEASE_CYC);

  logic [CW-1:0] cnt_q;
  logic [7:0]    step;

  always_comb begin
    step   = f_count_step(8'(cnt_q));
    expire = (cnt_q == CW'(1)) & ~cancel & ~load;
    busy   = (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cancel) cnt_q <= '0;
    else if (load)   cnt_q <= LOAD_VAL;
    else             cnt_q <= step[CW-1:0];
  end
endmodule

// File: rtl/i2c_byte_handshake.sv
module i2c_byte_handshake #(
  parameter int RELEASE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic addr_fmt,
  input  logic slave_rx,
  input  logic is_slave,
  input  logic evt_byte_done,
  input  logic evt_arb_lost,
  input  logic evt_addr_done,
  input  logic addr_match,
  input  logic evt_stop,
  input  logic wr_ctrl,
  input  logic wr_ctrl_flag,
  input  logic wr_shift,
  input  logic wr_txbuf,
  output logic byte_flag,
  output logic irq,
  output logic scl_hold
);
  logic clr_evt, set_req, rel_load, rel_cancel, rel_expire, rel_busy;
  logic flag_q, flag_d, flag_fall, stop_slave, irq_q;

  i2c_byte_handshake_clrdec u_clrdec (
    .enable(enable), .slave_rx(slave_rx), .addr_fmt(addr_fmt),
    .evt_byte_done(evt_byte_done), .evt_arb_lost(evt_arb_lost),
    .evt_addr_done(evt_addr_done), .addr_match(addr_match),
    .wr_ctrl(wr_ctrl), .wr_ctrl_flag(wr_ctrl_flag),
    .wr_shift(wr_shift), .wr_txbuf(wr_txbuf),
    .clr_evt(clr_evt), .set_req(set_req)
  );

  assign rel_load   = set_req & ~flag_q;
  assign rel_cancel = clr_evt | ~enable;

  i2c_byte_handshake_reltmr #(.RELEASE_CYC(RELEASE_CYC)) u_reltmr (
    .clk(clk), .rst_n(rst_n), .load(rel_load), .cancel(rel_cancel),
    .expire(rel_expire), .busy(rel_busy)
  );

  always_comb begin
    if (!enable)         flag_d = 1'b1;
    else if (clr_evt)    flag_d = 1'b0;
    else if (rel_expire) flag_d = 1'b1;
    else                 flag_d = flag_q;
    flag_fall  = flag_q & ~flag_d;
    stop_slave = enable & evt_stop & is_slave;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= flag_fall | stop_slave;
    end
  end

  assign byte_flag = flag_q;
  assign irq       = irq_q;
  assign scl_hold  = ~flag_q;
endmodule

// File: rtl/i2c_byte_handshake_chk.sv
module i2c_byte_handshake_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic byte_flag,
  input logic irq,
  input logic scl_hold,
  input logic clr_evt,
  input logic set_req,
  input logic stop_slave
);
  // R2 / R3
  a_r2_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && clr_evt) |=> !byte_flag);
  // R4
  a_r4_hold_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold != byte_flag);
  // R5
  a_r5_irq_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(byte_flag) |-> irq);
  // R5 / R6
  a_r5_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (($past(byte_flag) && !byte_flag) || $past(stop_slave)));
  // R6
  a_r6_stop_irq: assert property (@(posedge clk) disable iff (!rst_n)
    stop_slave |=> irq);
  // R7
  a_r7_no_early_release: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && set_req && !byte_flag && !clr_evt) |=> !byte_flag);
  // R9
  a_r9_disable_forces: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (byte_flag && !irq));
endmodule

bind i2c_byte_handshake i2c_byte_handshake_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .byte_flag(byte_flag),
  .irq(irq), .scl_hold(scl_hold), .clr_evt(clr_evt), .set_req(set_req),
  .stop_slave(stop_slave)
);

// File: tb/i2c_byte_handshake_tb.sv
`timescale 1ns/1ps
module i2c_byte_handshake_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1;
  logic addr_fmt, slave_rx, is_slave, evt_byte_done, evt_arb_lost, evt_addr_done;
  logic addr_match, evt_stop, wr_ctrl, wr_ctrl_flag, wr_shift, wr_txbuf;
  logic byte_flag, irq, scl_hold;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_byte_handshake u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .addr_fmt(addr_fmt),
    .slave_rx(slave_rx), .is_slave(is_slave), .evt_byte_done(evt_byte_done),
    .evt_arb_lost(evt_arb_lost), .evt_addr_done(evt_addr_done),
    .addr_match(addr_match), .evt_stop(evt_stop), .wr_ctrl(wr_ctrl),
    .wr_ctrl_flag(wr_ctrl_flag), .wr_shift(wr_shift), .wr_txbuf(wr_txbuf),
    .byte_flag(byte_flag), .irq(irq), .scl_hold(scl_hold)
  );

  // Vector: {req[4], stim[12], irq_now, flag_now, gap[4], flag_after}
  // stim bits: 11 byte_done, 10 arb_lost, 9 addr_done, 8 addr_match, 7 addr_fmt,
  // 6 slave_rx, 5 stop, 4 is_slave, 3 wr_ctrl, 2 ctrl_flag, 1 wr_shift, 0 wr_txbuf
  localparam int NV = 18;
  localparam logic [22:0] VEC [NV] = '{
    {4'd2,  12'b1000_0000_0000, 1'b1, 1'b0, 4'd3,  1'b0}, // R2 byte done clears
    {4'd7,  12'b0000_0000_1000, 1'b0, 1'b0, 4'd10, 1'b0}, // R7 ctrl write of 0 ignored
    {4'd7,  12'b0000_0000_1100, 1'b0, 1'b0, 4'd7,  1'b0}, // R7 still low one edge early
    {4'd7,  12'b0000_0000_0000, 1'b0, 1'b1, 4'd0,  1'b1}, // R7 high on the 8th edge
    {4'd2,  12'b0100_0000_0000, 1'b1, 1'b0, 4'd1,  1'b0}, // R2 arbitration lost
    {4'd7,  12'b0000_0000_0010, 1'b0, 1'b0, 4'd8,  1'b1}, // R7 shift write release
    {4'd3,  12'b0010_0100_0000, 1'b0, 1'b1, 4'd1,  1'b1}, // R3 fmt0 no match
    {4'd3,  12'b0011_0100_0000, 1'b1, 1'b0, 4'd0,  1'b0}, // R3 fmt0 match
    {4'd7,  12'b0000_0000_0001, 1'b0, 1'b0, 4'd8,  1'b1}, // R7 txbuf release
    {4'd3,  12'b0010_1100_0000, 1'b1, 1'b0, 4'd0,  1'b0}, // R3 fmt1 any address
    {4'd8,  12'b0000_0000_1100, 1'b0, 1'b0, 4'd3,  1'b0}, // R8 start release
    {4'd8,  12'b1000_0000_0000, 1'b0, 1'b0, 4'd12, 1'b0}, // R8 clear mid count wins
    {4'd7,  12'b0000_0000_0010, 1'b0, 1'b0, 4'd8,  1'b1}, // R7 release again
    {4'd3,  12'b0011_1000_0000, 1'b0, 1'b1, 4'd0,  1'b1}, // R3 not slave rx
    {4'd6,  12'b0000_0011_0000, 1'b1, 1'b1, 4'd0,  1'b1}, // R6 slave stop
    {4'd6,  12'b0000_0010_0000, 1'b0, 1'b1, 4'd0,  1'b1}, // R6 master stop quiet
    {4'd10, 12'b0000_0000_0010, 1'b0, 1'b1, 4'd9,  1'b1}, // R10 write while high
    {4'd11, 12'b1000_0000_1100, 1'b1, 1'b0, 4'd10, 1'b0}  // R11 clear beats write
  };

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [11:0] s);
    {evt_byte_done, evt_arb_lost, evt_addr_done, addr_match, addr_fmt, slave_rx,
     evt_stop, is_slave, wr_ctrl, wr_ctrl_flag, wr_shift, wr_txbuf} = s;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    drive(12'b0);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 flag in reset", byte_flag, 1'b1);
    check("R1 irq in reset", irq, 1'b0);
    check("R1 scl_hold in reset", scl_hold, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 flag after reset", byte_flag, 1'b1);

    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VEC[i];
      drive(v[18:7]);
      @(negedge clk);
      check($sformatf("R%0d vec%0d irq", v[22:19], i), irq, v[6]);
      check($sformatf("R%0d vec%0d flag", v[22:19], i), byte_flag, v[5]);
      check($sformatf("R4 vec%0d hold", i), scl_hold, ~v[5]);
      drive(12'b0);
      repeat (v[4:1]) @(negedge clk);
      check($sformatf("R%0d vec%0d flag later", v[22:19], i), byte_flag, v[0]);
      if (v[4:1] != 4'd0) check($sformatf("R5 vec%0d irq single pulse", i), irq, 1'b0);
    end

    // R9 disable forces flag high; slave stop and clear ignored
    enable = 1'b0;
    drive(12'b1000_0011_0000);
    @(negedge clk);
    check("R9 flag forced", byte_flag, 1'b1);
    check("R9 no irq", irq, 1'b0);
    check("R9 hold released", scl_hold, 1'b0);
    @(negedge clk);
    check("R9 clear ignored", byte_flag, 1'b1);
    drive(12'b0);
    enable = 1'b1;
    @(negedge clk);
    check("R9 flag stays after enable", byte_flag, 1'b1);

    // R1 reset during hold
    drive(12'b1000_0000_0000);
    @(negedge clk);
    drive(12'b0);
    check("R2 flag low before reset", byte_flag, 1'b0);
    rst_n = 1'b0;
    #1;
    check("R1 flag after mid reset", byte_flag, 1'b1);
    check("R1 hold after mid reset", scl_hold, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq after mid reset", irq, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule